// File: doc/BRIEF.md
# Double-Buffered Receive Status Interrupt Controller

This block tracks received packets for a network controller that lets the host queue receive commands back to back. The host can queue up to two "enable receive" commands. Each one names the buffer page that the next packet goes to. The receiver signals when a packet starts arriving and when it has finished. Each finished reception leaves a result, which is the page it used. Up to two results are kept. The oldest result is shown in the status view until the host acknowledges it with a clear command.

The host interrupt follows the oldest result. It rises once that result becomes visible and stays high until the clear command. If a second result is waiting, the status view moves to it straight away. Its interrupt is held back until the line has been inactive for a guaranteed number of cycles. The receive-inhibit mask bit gates only the interrupt, not the status flag. A disable command withdraws the oldest queued enable, but only if its reception has not yet begun.

Top module: `rx_status_irq`

## Requirements
- R1: After reset, `stat_rx_done`, `irq_o`, `stat_overflow`, `rx_armed` and `rx_busy` are all 0.
- R2: Receive enables are kept in arrival order, at most two at a time. `act_page` shows the page of the oldest one, and `rx_armed` is 1 while at least one is queued.
- R3: An `rx_start` pulse is accepted only when all three of these hold: a receive enable is queued, no reception is running, and fewer than two results are held. An accepted start sets `rx_busy`. An `rx_done` pulse while busy moves the oldest enable's page into the result store and clears `rx_busy`. Any other `rx_start` or `rx_done` pulse is ignored.
- R4: `stat_rx_done` is 1 while any result is held, and `stat_page` shows the oldest one. A result stays visible until a clear command removes it.
- R5: With the mask low, `irq_o` rises one cycle after `stat_rx_done` rises. It stays high until the clear command and falls on the same edge that removes the result.
- R6: After a clear, a waiting second result appears on `stat_rx_done`/`stat_page` immediately. `irq_o` stays low for exactly `GAP_CYC`+1 cycles and then rises again. This is 5 cycles with the default of 4.
- R7: When `irq_mask_ri` is 1, `irq_o` stays low and `stat_rx_done` is unaffected. When the mask returns to 0 with a result held and no gap running, `irq_o` rises one cycle later.
- R8: A disable command with no reception running removes the oldest queued enable. While a reception is running, a disable command has no effect. Two disable commands empty a full queue.
- R9: A clear command with no result held has no effect.
- R10: An enable command while two enables are queued is dropped and sets `stat_overflow`. The flag stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_enable_rx | input | 1 | One-cycle pulse: queue a receive enable |
| cmd_page | input | PAGE_W | Page carried by `cmd_enable_rx` |
| cmd_clear_rx | input | 1 | One-cycle pulse: acknowledge the oldest result |
| cmd_disable_rx | input | 1 | One-cycle pulse: cancel the oldest queued enable |
| rx_start | input | 1 | Receiver strobe: packet reception started |
| rx_done | input | 1 | Receiver strobe: packet reception finished |
| irq_mask_ri | input | 1 | Receive-inhibit mask for the interrupt |
| stat_rx_done | output | 1 | Receive-done flag of the status view |
| stat_page | output | PAGE_W | Page of the oldest held result |
| stat_overflow | output | 1 | Sticky flag: an enable was dropped |
| irq_o | output | 1 | Host receive interrupt |
| rx_armed | output | 1 | At least one receive enable is queued |
| rx_busy | output | 1 | A reception is in progress |
| act_page | output | PAGE_W | Page of the oldest queued enable |

## Verification
The main flow is tried with four patterns: a single reception, two back-to-back receptions, a reception under the mask, and a disable that arrives during a reception. The single case shows that the interrupt latches and drops on the edge of the clear. The back-to-back case separates a correct hold-off gap from an interrupt that never falls or comes back too early, because the bench counts the exact number of low cycles. The masked case and the busy disable show that the mask and the cancel touch only what they are meant to touch. Separate patterns cover starts, completions and clears that have nothing to act on, the third enable, and a start refused while both results are full.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
   // Default sizing shared by the block and its checker
   localparam int DEF_PAGE_W  = 4;
   localparam int DEF_DEPTH   = 2;
   localparam int DEF_GAP_CYC = 4;

   // Circular pointer advance for any depth
   function automatic int unsigned ptr_next(input int unsigned p, input int unsigned depth);
      return (p == depth - 1) ? 0 : p + 1;
   endfunction
endpackage

// File: rtl/rxq_fifo.sv
module rxq_fifo #(
   parameter int DEPTH = 2,
   parameter int W     = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] head,
   output logic         empty,
   output logic         full
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   if (DEPTH < 1) begin : g_bad_depth
      $error("rxq_fifo: DEPTH must be at least 1");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] rd_ptr, wr_ptr;
   logic [CW-1:0] cnt;
   logic          do_push, do_pop;

   assign empty   = (cnt == '0);
   assign full    = (cnt == CW'(DEPTH));
   assign do_push = push & ~full;
   assign do_pop  = pop & ~empty;
   assign head    = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (do_push) wr_ptr <= PW'(rxq_pkg::ptr_next(int'(wr_ptr), DEPTH));
         if (do_pop)  rd_ptr <= PW'(rxq_pkg::ptr_next(int'(rd_ptr), DEPTH));
         case ({do_push, do_pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end
endmodule

// File: rtl/rxq_irq_gap.sv
module rxq_irq_gap #(
   parameter int GAP_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic want,
   input  logic drop,
   output logic irq
);
   if (GAP_CYC < 0) begin : g_bad_gap
      $error("rxq_irq_gap: GAP_CYC must not be negative");
   end

   logic irq_q;
   assign irq = irq_q;

   if (GAP_CYC == 0) begin : g_nogap
      always_ff @(posedge clk) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= want & ~drop;
      end
   end else begin : g_gap
      localparam int GW = $clog2(GAP_CYC + 1);
      logic [GW-1:0] gap_cnt;
      logic          irq_d;

      assign irq_d = want & ~drop & (gap_cnt == '0);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            irq_q   <= 1'b0;
            gap_cnt <= '0;
         end else begin
            irq_q <= irq_d;
            if (irq_q && !irq_d)    gap_cnt <= GW'(GAP_CYC);
            else if (gap_cnt != '0) gap_cnt <= gap_cnt - 1'b1;
         end
      end
   end
endmodule

// File: rtl/rx_status_irq.sv
module rx_status_irq #(
   parameter int PAGE_W  = rxq_pkg::DEF_PAGE_W,
   parameter int DEPTH   = rxq_pkg::DEF_DEPTH,
   parameter int GAP_CYC = rxq_pkg::DEF_GAP_CYC
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_enable_rx,
   input  logic [PAGE_W-1:0] cmd_page,
   input  logic              cmd_clear_rx,
   input  logic              cmd_disable_rx,
   input  logic              rx_start,
   input  logic              rx_done,
   input  logic              irq_mask_ri,
   output logic              stat_rx_done,
   output logic [PAGE_W-1:0] stat_page,
   output logic              stat_overflow,
   output logic              irq_o,
   output logic              rx_armed,
   output logic              rx_busy,
   output logic [PAGE_W-1:0] act_page
);
   if (PAGE_W < 1) begin : g_bad_page
      $error("rx_status_irq: PAGE_W must be at least 1");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("rx_status_irq: DEPTH must be at least 2 for chaining");
   end

   logic              en_empty, en_full, res_empty, res_full;
   logic              en_push, en_pop, res_push, res_pop;
   logic              start_ok, done_ok, busy_q, ovf_q;
   logic [PAGE_W-1:0] en_head, res_head;

   assign en_push  = cmd_enable_rx & ~en_full;
   assign start_ok = rx_start & ~busy_q & ~en_empty & ~res_full;
   assign done_ok  = rx_done & busy_q;
   assign en_pop   = done_ok | (cmd_disable_rx & ~busy_q & ~en_empty);
   assign res_push = done_ok;
   assign res_pop  = cmd_clear_rx & ~res_empty;

   rxq_fifo #(.DEPTH(DEPTH), .W(PAGE_W)) u_en_q (
      .clk(clk), .rst_n(rst_n),
      .push(en_push), .din(cmd_page), .pop(en_pop),
      .head(en_head), .empty(en_empty), .full(en_full)
   );

   rxq_fifo #(.DEPTH(DEPTH), .W(PAGE_W)) u_res_q (
      .clk(clk), .rst_n(rst_n),
      .push(res_push), .din(en_head), .pop(res_pop),
      .head(res_head), .empty(res_empty), .full(res_full)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         ovf_q  <= 1'b0;
      end else begin
         if (start_ok)     busy_q <= 1'b1;
         else if (done_ok) busy_q <= 1'b0;
         if (cmd_enable_rx && en_full) ovf_q <= 1'b1;
      end
   end

   rxq_irq_gap #(.GAP_CYC(GAP_CYC)) u_irq (
      .clk(clk), .rst_n(rst_n),
      .want(~res_empty & ~irq_mask_ri),
      .drop(res_pop),
      .irq(irq_o)
   );

   assign stat_rx_done  = ~res_empty;
   assign stat_page     = res_head;
   assign stat_overflow = ovf_q;
   assign rx_armed      = ~en_empty;
   assign rx_busy       = busy_q;
   assign act_page      = en_head;
endmodule

// File: rtl/rx_status_irq_chk.sv
module rx_status_irq_chk #(
   parameter int GAP_CYC = 4
) (
   input logic clk,
   input logic rst_n,
   input logic cmd_clear_rx,
   input logic rx_done,
   input logic irq_mask_ri,
   input logic stat_rx_done,
   input logic stat_overflow,
   input logic irq_o,
   input logic rx_armed,
   input logic rx_busy
);
   logic [15:0] low_cnt;
   logic        had_irq;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         low_cnt <= '0;
         had_irq <= 1'b0;
      end else begin
         if (irq_o) begin
            low_cnt <= '0;
            had_irq <= 1'b1;
         end else if (low_cnt != 16'hFFFF) begin
            low_cnt <= low_cnt + 1'b1;
         end
      end
   end

   // R5
   irq_has_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> stat_rx_done);

   // R7
   mask_blocks_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(irq_mask_ri) |-> !irq_o);

   // R6
   idle_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(irq_o) && had_irq) |-> (low_cnt >= GAP_CYC));

   // R4
   result_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rx_done && !cmd_clear_rx) |=> stat_rx_done);

   // R9
   empty_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_clear_rx && !stat_rx_done && !rx_done) |=> !stat_rx_done);

   // R10
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stat_overflow |=> stat_overflow);

   // R3
   busy_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_busy |-> rx_armed);
endmodule

bind rx_status_irq rx_status_irq_chk #(.GAP_CYC(GAP_CYC)) u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_clear_rx(cmd_clear_rx), .rx_done(rx_done),
   .irq_mask_ri(irq_mask_ri), .stat_rx_done(stat_rx_done),
   .stat_overflow(stat_overflow), .irq_o(irq_o), .rx_armed(rx_armed),
   .rx_busy(rx_busy)
);

// File: tb/rx_status_irq_tb.sv
module rx_status_irq_tb;
   localparam int PW  = 4;
   localparam int GAP = 4;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cmd_enable_rx = 0, cmd_clear_rx = 0, cmd_disable_rx = 0;
   logic rx_start = 0, rx_done = 0, irq_mask_ri = 0;
   logic [PW-1:0] cmd_page = '0;
   logic stat_rx_done, stat_overflow, irq_o, rx_armed, rx_busy;
   logic [PW-1:0] stat_page, act_page;
   int n_chk = 0, n_fail = 0;

   always #5 clk = ~clk;

   rx_status_irq #(.PAGE_W(PW), .DEPTH(2), .GAP_CYC(GAP)) u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_enable_rx(cmd_enable_rx), .cmd_page(cmd_page),
      .cmd_clear_rx(cmd_clear_rx), .cmd_disable_rx(cmd_disable_rx),
      .rx_start(rx_start), .rx_done(rx_done), .irq_mask_ri(irq_mask_ri),
      .stat_rx_done(stat_rx_done), .stat_page(stat_page), .stat_overflow(stat_overflow),
      .irq_o(irq_o), .rx_armed(rx_armed), .rx_busy(rx_busy), .act_page(act_page)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic do_enable(input logic [PW-1:0] p);
      @(negedge clk); cmd_enable_rx = 1; cmd_page = p;
      @(negedge clk); cmd_enable_rx = 0;
   endtask
   task automatic do_clear();
      @(negedge clk); cmd_clear_rx = 1;
      @(negedge clk); cmd_clear_rx = 0;
   endtask
   task automatic do_disable();
      @(negedge clk); cmd_disable_rx = 1;
      @(negedge clk); cmd_disable_rx = 0;
   endtask
   task automatic do_start();
      @(negedge clk); rx_start = 1;
      @(negedge clk); rx_start = 0;
   endtask
   task automatic do_done();
      @(negedge clk); rx_done = 1;
      @(negedge clk); rx_done = 0;
   endtask

   task automatic t_reset();
      chk("R1 stat_rx_done", stat_rx_done, 0);
      chk("R1 irq", irq_o, 0);
      chk("R1 overflow", stat_overflow, 0);
      chk("R1 armed", rx_armed, 0);
      chk("R1 busy", rx_busy, 0);
   endtask

   task automatic t_single();
      idle(10);
      do_enable(4'd6);
      chk("R2 armed", rx_armed, 1);
      chk("R2 act_page", act_page, 6);
      do_start();
      chk("R3 busy after start", rx_busy, 1);
      do_done();
      chk("R3 busy after done", rx_busy, 0);
      chk("R4 stat_rx_done", stat_rx_done, 1);
      chk("R4 stat_page", stat_page, 6);
      chk("R5 irq same cycle", irq_o, 0);
      @(negedge clk);
      chk("R5 irq next cycle", irq_o, 1);
      idle(6);
      chk("R5 irq held", irq_o, 1);
      chk("R4 result held", stat_rx_done, 1);
      do_clear();
      chk("R5 irq drops on clear", irq_o, 0);
      chk("R4 cleared", stat_rx_done, 0);
   endtask

   task automatic t_two_results();
      int lows;
      idle(10);
      do_enable(4'd1);
      do_enable(4'd2);
      do_start(); do_done();
      do_start(); do_done();
      @(negedge clk);
      chk("R4 oldest page", stat_page, 1);
      chk("R5 irq first", irq_o, 1);
      do_clear();
      chk("R6 second visible", stat_rx_done, 1);
      chk("R6 second page", stat_page, 2);
      lows = 0;
      while (!irq_o && lows < 20) begin
         lows++;
         @(negedge clk);
      end
      chk("R6 idle gap cycles", lows, GAP + 1);
      do_clear();
      chk("R6 both cleared", stat_rx_done, 0);
   endtask

   task automatic t_mask();
      idle(10);
      irq_mask_ri = 1;
      do_enable(4'd7); do_start(); do_done();
      idle(4);
      chk("R7 flag under mask", stat_rx_done, 1);
      chk("R7 irq masked", irq_o, 0);
      irq_mask_ri = 0;
      @(negedge clk);
      chk("R7 irq after unmask", irq_o, 1);
      do_clear();
   endtask

   task automatic t_disable();
      idle(10);
      do_enable(4'd4); do_enable(4'd8);
      do_start();
      do_disable();
      chk("R8 disable while busy armed", rx_armed, 1);
      chk("R8 disable while busy page", act_page, 4);
      do_done();
      chk("R8 completed page", stat_page, 4);
      do_clear();
      chk("R8 next enable", act_page, 8);
      do_disable();
      chk("R8 cancelled", rx_armed, 0);
      do_enable(4'd3); do_enable(4'd5);
      do_disable();
      chk("R8 first of two", act_page, 5);
      do_disable();
      chk("R8 second of two", rx_armed, 0);
   endtask

   task automatic t_ignored();
      idle(10);
      do_clear();
      chk("R9 clear empty flag", stat_rx_done, 0);
      chk("R9 clear empty irq", irq_o, 0);
      do_done();
      chk("R3 stray done", stat_rx_done, 0);
      do_start();
      chk("R3 start without enable", rx_busy, 0);
      do_enable(4'd9); do_enable(4'd10); do_enable(4'd11);
      chk("R10 overflow set", stat_overflow, 1);
      chk("R10 oldest kept", act_page, 9);
      do_start(); do_done();
      do_start(); do_done();
      do_enable(4'd12);
      do_start();
      chk("R3 start refused when results full", rx_busy, 0);
      chk("R3 enable remains", act_page, 12);
      do_clear(); do_clear();
      do_disable();
      chk("R10 overflow sticky", stat_overflow, 1);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_single();
      t_two_results();
      t_mask();
      t_disable();
      t_ignored();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule